// File: doc/BRIEF.md
# Serial Scan Test Wrapper for a Wide Adder

This block lets a wide adder be exercised through a handful of serial pins. After a start pulse, the two operands are clocked in one bit per enabled cycle into an input shift register. Operand A goes first, operand B second, and each is sent least significant bit first.

Once the input register is full, the wrapper sequences a fixed set of steps:

- A launch strobe copies the operands onto the adder inputs.
- On the next cycle, a capture strobe latches the sum into a dedicated capture register.
- The captured value is then moved in parallel into an output shift register.
- The output register is unloaded serially: the sum bits first, least significant first, and the carry-out last.

The launch and capture strobes are brought out on two observation pins. A swap control exchanges which strobe appears on which pin, so an off-chip delay mismatch between the two pins can be measured twice and averaged out.

Top module: `scan_adder_wrap`

## Requirements
- R1: During reset and just after it, the wrapper is idle, and `scan_out`, `done`, `obs_a` and `obs_b` are all 0.
- R2: In the load phase, each cycle with `scan_en`=1 shifts one `scan_in` bit into the input register. Cycles with `scan_en`=0 leave the input register and the bit count unchanged. Bit k of the stream (k from 0) is A[k] for k < W and B[k-W] otherwise. After 2W shifts, the load phase ends.
- R3: In the cycle after the last input shift, the launch strobe is high for exactly one cycle, and the loaded operands are applied to the adder.
- R4: The capture strobe is high for exactly one cycle, in the cycle right after the launch strobe. It latches the (W+1)-bit sum of the applied operands into the capture register.
- R5: One cycle after capture, the captured value is transferred to the output register. From the next cycle on, `scan_out` shows result bit 0. The W+1 result bits appear least significant first, with the carry-out last.
- R6: In the unload phase, the output register shifts by one bit only on cycles with `scan_en`=1. After W+1 shifts, the wrapper returns to idle.
- R7: With `swap_sel`=0, `obs_a` shows the launch strobe and `obs_b` shows the capture strobe. With `swap_sel`=1, the two are exchanged.
- R8: A `start` pulse is accepted only while idle. A pulse during any other phase does not change the sequence or the result.
- R9: `done` rises in the cycle after the last output shift. It stays high until the next accepted `start`, and it is cleared on that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | Enables one shift step in the load and unload phases |
| scan_in | input | 1 | Serial operand data |
| start | input | 1 | Begins a load phase when the wrapper is idle |
| swap_sel | input | 1 | Exchanges the strobes on the two observation pins |
| scan_out | output | 1 | Serial result data (bit 0 of the output register) |
| done | output | 1 | Result fully unloaded |
| obs_a | output | 1 | Observation pin: launch strobe, or capture strobe when swapped |
| obs_b | output | 1 | Observation pin: capture strobe, or launch strobe when swapped |

## Verification
The launch strobe is due one cycle after the clock edge that takes the last input bit. Capture follows one cycle later, and the transfer one cycle after that. The first result bit is therefore readable on `scan_out` four cycles after the final input shift, and every later bit one enabled cycle after the previous one.

A behavioural model advances on each rising edge with the same inputs as the wrapper. Every output is compared against it at the falling edge, so any one-cycle slip in a strobe, in `done` or in the serial data is reported. Inputs change a short time after the falling edge, so the combinational strobe routing is never sampled mid-change. Runs with stalled shifts, swapped routing and a start pulse while busy test the timing under each condition.

// File: rtl/scan_adder_wrap.sv
module scan_adder_wrap #(
  parameter int W = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic scan_in,
  input  logic start,
  input  logic swap_sel,
  output logic scan_out,
  output logic done,
  output logic obs_a,
  output logic obs_b
);
  localparam int IN_BITS  = 2 * W;
  localparam int OUT_BITS = W + 1;
  localparam int CW       = $clog2(IN_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_LAUNCH, ST_CAPT, ST_XFER, ST_UNLOAD
  } st_t;

  st_t                state;
  logic [CW-1:0]      cnt;
  logic [IN_BITS-1:0] in_sr;
  logic [W-1:0]       op_a, op_b;
  logic [W:0]         cap_q, out_sr, sum_w;
  logic               launch_stb, capture_stb;

  assign launch_stb  = (state == ST_LAUNCH);
  assign capture_stb = (state == ST_CAPT);
  assign sum_w       = {1'b0, op_a} + {1'b0, op_b};

  assign scan_out = out_sr[0];
  assign obs_a    = swap_sel ? capture_stb : launch_stb;
  assign obs_b    = swap_sel ? launch_stb  : capture_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      in_sr  <= '0;
      op_a   <= '0;
      op_b   <= '0;
      cap_q  <= '0;
      out_sr <= '0;
      done   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:
          if (start) begin
            state <= ST_LOAD;
            cnt   <= '0;
            done  <= 1'b0;
          end
        ST_LOAD:
          if (scan_en) begin
            in_sr <= {scan_in, in_sr[IN_BITS-1:1]};
            if (cnt == CW'(IN_BITS - 1)) begin
              state <= ST_LAUNCH;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        ST_LAUNCH: begin
          op_a  <= in_sr[W-1:0];
          op_b  <= in_sr[IN_BITS-1:W];
          state <= ST_CAPT;
        end
        ST_CAPT: begin
          cap_q <= sum_w;
          state <= ST_XFER;
        end
        ST_XFER: begin
          out_sr <= cap_q;
          state  <= ST_UNLOAD;
        end
        ST_UNLOAD:
          if (scan_en) begin
            out_sr <= {1'b0, out_sr[W:1]};
            if (cnt == CW'(OUT_BITS - 1)) begin
              state <= ST_IDLE;
              cnt   <= '0;
              done  <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_adder_wrap_chk.sv
module scan_adder_wrap_chk #(
  parameter int W = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           scan_en,
  input logic           swap_sel,
  input logic           done,
  input logic           launch_stb,
  input logic           capture_stb,
  input logic           obs_a,
  input logic           obs_b,
  input logic           loading,
  input logic [2*W-1:0] in_sr
);
  // R3
  launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |=> !launch_stb);

  // R4
  capture_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |=> capture_stb);

  // R4
  capture_has_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_stb |-> $past(launch_stb));

  // R2
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && !scan_en) |=> $stable(in_sr));

  // R7
  obs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_a && !swap_sel) |=> (obs_b || swap_sel));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind scan_adder_wrap scan_adder_wrap_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .scan_en(scan_en),
  .swap_sel(swap_sel), .done(done), .launch_stb(launch_stb),
  .capture_stb(capture_stb), .obs_a(obs_a), .obs_b(obs_b),
  .loading(state == ST_LOAD), .in_sr(in_sr)
);

// File: tb/scan_adder_wrap_bench.sv
module scan_adder_wrap_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 0, rst_n = 0, scan_en = 0, scan_in = 0, start = 0, swap_sel = 0;
  logic scan_out, done, obs_a, obs_b;
  int checks = 0, failures = 0;
  bit finished = 0;

  scan_adder_wrap #(.W(W)) u_scan_adder_wrap (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .start(start), .swap_sel(swap_sel), .scan_out(scan_out), .done(done),
    .obs_a(obs_a), .obs_b(obs_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int         mph = 0, mcnt = 0;
  bit         min_q[$];
  bit         mout_q[$];
  logic [W-1:0] ma, mb;
  logic [W:0]   mcap;
  bit         mdone = 0;

  initial for (int i = 0; i <= W; i++) mout_q.push_back(1'b0);

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mcnt = 0; mdone = 0; min_q.delete();
    end else begin
      case (mph)
        0: if (start) begin mph = 1; mcnt = 0; mdone = 0; end
        1: if (scan_en) begin
             min_q.push_back(scan_in); mcnt++;
             if (mcnt == 2*W) begin mph = 2; mcnt = 0; end
           end
        2: begin
             for (int i = 0; i < W; i++) begin ma[i] = min_q[i]; mb[i] = min_q[W+i]; end
             min_q.delete(); mph = 3;
           end
        3: begin mcap = {1'b0, ma} + {1'b0, mb}; mph = 4; end
        4: begin
             mout_q.delete();
             for (int i = 0; i <= W; i++) mout_q.push_back(mcap[i]);
             mph = 5;
           end
        5: if (scan_en) begin
             void'(mout_q.pop_front()); mout_q.push_back(1'b0); mcnt++;
             if (mcnt == W+1) begin mph = 0; mcnt = 0; mdone = 1; end
           end
        default: mph = 0;
      endcase
    end
  end

  task automatic check(bit ok, string tag, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit la, ca;
      la = (mph == 2); ca = (mph == 3);
      check(scan_out === mout_q[0], "R5 R6 scan_out per cycle", W'(scan_out), W'(mout_q[0]));
      check(done === mdone, "R9 done per cycle", W'(done), W'(mdone));
      check(obs_a === (swap_sel ? ca : la), "R3 R4 R7 obs_a per cycle", W'(obs_a), W'(swap_sel ? ca : la));
      check(obs_b === (swap_sel ? la : ca), "R3 R4 R7 obs_b per cycle", W'(obs_b), W'(swap_sel ? la : ca));
    end
  end

  task automatic run_vec(logic [W-1:0] a, logic [W-1:0] b, bit stall, bit busy_start);
    logic [W:0] got, exp;
    exp = {1'b0, a} + {1'b0, b};
    @(negedge clk); #1 start = 1;
    @(negedge clk); #1 start = 0;
    for (int i = 0; i < 2*W; i++) begin
      if (stall && (i % 5 == 2)) begin
        scan_en = 0; scan_in = ~scan_in;
        @(negedge clk); #1;
      end
      scan_en = 1;
      scan_in = (i < W) ? a[i] : b[i-W];
      start = busy_start && (i == 7);
      @(negedge clk); #1;
      start = 0;
    end
    scan_en = 0;
    for (int k = 0; k < 2; k++) begin
      start = busy_start;
      @(negedge clk); #1;
    end
    start = 0;
    @(negedge clk); #1;
    for (int j = 0; j <= W; j++) begin
      @(negedge clk);
      got[j] = scan_out;
      #1;
      if (stall && (j % 4 == 1)) begin
        scan_en = 0; start = busy_start;
        @(negedge clk); #1;
        start = 0;
      end
      scan_en = 1;
    end
    @(negedge clk);
    check(got === exp, "R5 serial result vs reference sum", got, exp);
    check(done === 1'b1, "R9 done after last shift", W'(done), W'(1));
    #1 scan_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scan_out === 0 && done === 0 && obs_a === 0 && obs_b === 0,
          "R1 outputs in reset", {scan_out, done, obs_a, obs_b}, 0);
    #1 rst_n = 1;
    @(negedge clk);
    check(scan_out === 0 && done === 0 && obs_a === 0 && obs_b === 0,
          "R1 outputs after reset", {scan_out, done, obs_a, obs_b}, 0);
    // R2 R5 plain runs
    run_vec(32'h0000_0001, 32'h0000_0002, 0, 0);
    run_vec(32'hFFFF_FFFF, 32'h0000_0001, 0, 0);
    run_vec(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    // R2 R6 stalled shifting
    run_vec(32'h1234_5678, 32'h9ABC_DEF0, 1, 0);
    // R7 swapped routing
    #1 swap_sel = 1;
    run_vec(32'hA5A5_A5A5, 32'h5A5A_5A5B, 0, 0);
    // R8 start pulses while busy
    run_vec(32'h8000_0000, 32'h8000_0000, 1, 1);
    #1 swap_sel = 0;
    run_vec(32'h0F0F_0F0F, 32'hF0F0_F0F0, 0, 1);
    repeat (3) @(negedge clk);
    check(done === 1'b1, "R9 done holds while idle", W'(done), W'(1));
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog R1..R9 run did not complete actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule